// File: doc/BRIEF.md
# Index/Data Configuration Register Port

This block is a byte-wide bank of 256 configuration registers reached through two adjacent I/O addresses. A write to the lower address (the index port) picks which register is current; a write to the upper address (the data port) updates the current register, provided that register's write rule lets the value through. A read at either address returns the current register one cycle later.

Most of the bank is locked. A small set of registers accepts any byte. Two registers accept only one particular key value and drop every other value. The whole two-address window answers only while an external enable input is high. That input is driven from bit 1 of a control byte held elsewhere, and it is low after reset. Six registers come out of reset with fixed non-zero contents.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the index latch holds 0x00, rdata is 0xFF, registers 0xE0, 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8 hold 0x3C, 0x03, 0xFC, 0xDE, 0xFE and 0xBE, and every other register holds 0x00.
- R2: With the window enabled, a write at BASE_ADDR (default 0x03F0) stores wdata[7:0] as the current index.
- R3: With the window enabled, rd_en at BASE_ADDR or at BASE_ADDR+1 makes rdata equal to the current register on the next clock edge. Without rd_en, rdata holds its value.
- R4: A data-port write is dropped when the current index is in 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R5: A data-port write at index 0xE7 is stored only if the byte is 0xFE, and at index 0xE8 only if the byte is 0xBE. Any other byte leaves the register unchanged.
- R6: A data-port write at index 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC stores any byte.
- R7: While win_en is 0, a read returns 0xFF, and writes to either port change neither the index nor any register.
- R8: Accesses to addresses other than the two ports leave the index and registers unchanged, and a read there returns 0xFF.
- R9: When a data-port write and a read occur in the same cycle, the read returns the register's value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| win_en | input | 1 | Window enable from the host control byte (bit 1) |
| addr | input | ADDR_W (16) | I/O address of the access |
| wdata | input | DATA_W (8) | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | DATA_W (8) | Registered read data |

## Verification
Index and register writes take effect at the edge that samples wr_en, so any later access sees the new value. Read data is due exactly one edge after the edge that samples rd_en. The bench drives every strobe on a falling edge and pushes the expected byte into a queue at the same moment. A monitor registers that a read was issued and compares rdata on the next falling edge, half a cycle after the result edge, so every comparison lands in the one cycle where the result is due. Write-only stimulus such as locked, keyed, disabled or off-window writes is checked through later reads of the same index.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

   // Write rule for one register of the bank
   typedef enum logic [1:0] {
      WP_LOCKED = 2'd0,   // data writes dropped
      WP_OPEN   = 2'd1,   // any byte stored
      WP_KEYED  = 2'd2    // only the key byte stored
   } wpol_e;

   function automatic wpol_e wpol(input int unsigned i);
      case (i)
         'hE7, 'hE8: return WP_KEYED;
         'hE0, 'hE1, 'hE2, 'hE3, 'hE6, 'hEE, 'hEF, 'hF0,
         'hF1, 'hF2, 'hF4, 'hF6, 'hF8, 'hFC: return WP_OPEN;
         default: return WP_LOCKED;
      endcase
   endfunction

   function automatic logic [7:0] key_val(input int unsigned i);
      case (i)
         'hE7:    return 8'hFE;
         'hE8:    return 8'hBE;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] rst_val(input int unsigned i);
      case (i)
         'hE0:    return 8'h3C;
         'hE2:    return 8'h03;
         'hE3:    return 8'hFC;
         'hE6:    return 8'hDE;
         'hE7:    return 8'hFE;
         'hE8:    return 8'hBE;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] BASE_ADDR = 16'h03F0
) (
   input  logic              win_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic              idx_wr,
   output logic              dat_wr,
   output logic              rd_hit
);
   localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE_ADDR) + ADDR_W'(1);

   logic at_idx, at_dat;

   always_comb begin
      at_idx = win_en && (addr == IDX_ADDR);
      at_dat = win_en && (addr == DAT_ADDR);
      idx_wr = wr_en && at_idx;
      dat_wr = wr_en && at_dat;
      rd_hit = rd_en && (at_idx || at_dat);
   end
endmodule

// File: rtl/sio_wr_filter.sv
module sio_wr_filter
   import sio_cfg_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] din,
   output logic              ok
);
   always_comb begin
      case (wpol(int'(idx)))
         WP_OPEN:  ok = 1'b1;
         WP_KEYED: ok = (din == DATA_W'(key_val(int'(idx))));
         default:  ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
   import sio_cfg_pkg::*;
#(
   parameter int NUM_REGS    = 256,
   parameter int DATA_W      = 8,
   parameter bit PRUNE_FIXED = 1'b1,
   localparam int IDX_W      = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rval
);
   logic [DATA_W-1:0] cells [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
      localparam wpol_e             POL  = wpol(i);
      localparam logic [DATA_W-1:0] INIT = DATA_W'(rst_val(i));
      if (PRUNE_FIXED && POL != WP_OPEN) begin : g_const
         // a locked cell never changes; a keyed cell only accepts its reset value
         assign cells[i] = INIT;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= INIT;
            else if (we && widx == IDX_W'(i))
               q <= wdata;
         end
         assign cells[i] = q;
      end
   end

   assign rval = cells[ridx];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
   parameter int          ADDR_W      = 16,
   parameter int          DATA_W      = 8,
   parameter logic [15:0] BASE_ADDR   = 16'h03F0,
   parameter bit          PRUNE_FIXED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata
);
   localparam int NUM_REGS = 1 << DATA_W;
   localparam int IDX_W    = DATA_W;

   // elaboration checks
   if (DATA_W != 8) begin : g_bad_width
      $error("sio_cfg_port: write rules are defined for an 8-bit index only");
   end
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr_w
      $error("sio_cfg_port: ADDR_W must be 2..16");
   end
   if (BASE_ADDR[0] != 1'b0) begin : g_bad_base
      $error("sio_cfg_port: BASE_ADDR must be even");
   end

   logic              idx_wr, dat_wr, rd_hit, wr_ok, bank_we;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] rval;

   sio_port_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .win_en (win_en),
      .addr   (addr),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .idx_wr (idx_wr),
      .dat_wr (dat_wr),
      .rd_hit (rd_hit)
   );

   sio_wr_filter #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_flt (
      .idx (idx_q),
      .din (wdata),
      .ok  (wr_ok)
   );

   assign bank_we = dat_wr && wr_ok;

   sio_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PRUNE_FIXED(PRUNE_FIXED)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we),
      .widx  (idx_q),
      .wdata (wdata),
      .ridx  (idx_q),
      .rval  (rval)
   );

   // index latch
   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (idx_wr)
         idx_q <= IDX_W'(wdata);
   end

   AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> idx_q == $past(wdata));                              // R2
   AST_IDX_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en |=> $stable(idx_q));                                    // R7
   AST_NO_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en |-> !bank_we);                                          // R7

   // read data register, one cycle latency
   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '1;
      else if (rd_en)
         rdata <= rd_hit ? rval : '1;
   end

   AST_READ_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> rdata == $past(rval));                               // R3
   AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));                                     // R3
   AST_READ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !win_en) |=> rdata == '1);                            // R7
endmodule

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
   localparam logic [15:0] IDXP = 16'h03F0;
   localparam logic [15:0] DATP = 16'h03F1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        win_en = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic       pend = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   sio_cfg_port uut (
      .clk(clk), .rst_n(rst_n), .win_en(win_en), .addr(addr),
      .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   // monitor: a read sampled at a rising edge is compared at the next falling edge
   always @(posedge clk) pend <= rd_en;
   always @(negedge clk) begin
      if (pend && exp_q.size() > 0) begin
         check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_idx(input logic [7:0] i, input logic [7:0] exp, input string tag);
      wr(IDXP, i);
      rd(DATP, exp, tag);
   endtask

   // same-cycle read and data write
   task automatic rw(input logic [7:0] d, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr = DATP; wdata = d; wr_en = 1'b1; rd_en = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] open_set [14] = '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6, 8'hEE, 8'hEF,
                                    8'hF0, 8'hF1, 8'hF2, 8'hF4, 8'hF6, 8'hF8, 8'hFC};
      logic [7:0] lock_set [16] = '{8'h00, 8'h01, 8'h5A, 8'hDF, 8'hE4, 8'hE5, 8'hE9, 8'hEB,
                                    8'hED, 8'hF3, 8'hF5, 8'hF7, 8'hF9, 8'hFB, 8'hFD, 8'hFF};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rdata after reset", rdata, 8'hFF);

      // R7: disabled window reads 0xFF
      rd(DATP, 8'hFF, "R7 read while disabled");

      win_en = 1'b1;
      // R1: index resets to 0, register 0 resets to 0
      rd(IDXP, 8'h00, "R1 index 0 after reset");
      rd_idx(8'hE0, 8'h3C, "R1 reset 0xE0");
      rd_idx(8'hE1, 8'h00, "R1 reset 0xE1");
      rd_idx(8'hE2, 8'h03, "R1 reset 0xE2");
      rd_idx(8'hE3, 8'hFC, "R1 reset 0xE3");
      rd_idx(8'hE6, 8'hDE, "R1 reset 0xE6");
      rd_idx(8'hE7, 8'hFE, "R1 reset 0xE7");
      rd_idx(8'hE8, 8'hBE, "R1 reset 0xE8");
      rd_idx(8'hFC, 8'h00, "R1 reset 0xFC");

      // R2/R3: index write then read at both ports
      wr(IDXP, 8'hE3);
      rd(IDXP, 8'hFC, "R3 read at index port");
      rd(DATP, 8'hFC, "R2 R3 read at data port");

      // R6: writable set accepts any byte
      foreach (open_set[k]) begin
         wr(IDXP, open_set[k]);
         wr(DATP, open_set[k] ^ 8'hA5);
      end
      foreach (open_set[k]) rd_idx(open_set[k], open_set[k] ^ 8'hA5, "R6 open write");
      wr(IDXP, 8'hF0);
      wr(DATP, 8'h00);
      rd(DATP, 8'h00, "R6 open write zero");
      wr(DATP, 8'hFF);
      rd(IDXP, 8'hFF, "R6 open write ones");

      // R4: locked indices drop data writes
      foreach (lock_set[k]) begin
         wr(IDXP, lock_set[k]);
         wr(DATP, 8'h77);
         rd(DATP, 8'h00, "R4 locked index");
      end

      // R5: keyed indices
      wr(IDXP, 8'hE7);
      wr(DATP, 8'h12);
      rd(DATP, 8'hFE, "R5 0xE7 wrong key");
      wr(DATP, 8'hFF);
      rd(DATP, 8'hFE, "R5 0xE7 near key");
      wr(DATP, 8'hFE);
      rd(DATP, 8'hFE, "R5 0xE7 key");
      wr(IDXP, 8'hE8);
      wr(DATP, 8'h00);
      rd(DATP, 8'hBE, "R5 0xE8 wrong key");
      wr(DATP, 8'hFE);
      rd(DATP, 8'hBE, "R5 0xE8 other key");
      wr(DATP, 8'hBE);
      rd(IDXP, 8'hBE, "R5 0xE8 key");

      // R7: disabled writes change nothing
      wr(IDXP, 8'hE0);
      rd(DATP, 8'hE0 ^ 8'hA5, "R7 setup");
      win_en = 1'b0;
      wr(IDXP, 8'hE1);
      wr(DATP, 8'h33);
      rd(IDXP, 8'hFF, "R7 index-port read disabled");
      rd(DATP, 8'hFF, "R7 data-port read disabled");
      win_en = 1'b1;
      rd(DATP, 8'hE0 ^ 8'hA5, "R7 index and data untouched");
      rd_idx(8'hE1, 8'hE1 ^ 8'hA5, "R7 other register untouched");

      // R8: off-window addresses
      wr(IDXP, 8'hE2);
      wr(16'h03F2, 8'hE3);
      wr(16'h02F0, 8'hE3);
      wr(16'h02F1, 8'h11);
      wr(16'h13F1, 8'h22);
      rd(16'h03F2, 8'hFF, "R8 off-window read");
      rd(16'h13F0, 8'hFF, "R8 aliased off-window read");
      rd(DATP, 8'hE2 ^ 8'hA5, "R8 index and data untouched");

      // R9: read and write in one cycle
      rw(8'h4B, 8'hE2 ^ 8'hA5, "R9 read sees old value");
      rd(DATP, 8'h4B, "R9 write landed");

      // R1: second reset restores defaults
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd(DATP, 8'h00, "R1 index cleared by reset");
      rd_idx(8'hE2, 8'h03, "R1 reset restores 0xE2");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; fails++;
         $display("FAIL R3: actual %0d reads unanswered expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule